// File: doc/BRIEF.md
# Page Table Walker

This block refills the translation buffer after a miss by fetching one entry from a single-level page table held in memory. A miss request carries a 32-bit virtual address; its upper 20 bits form the virtual page number (VPN), which is checked against an inclusive lower/upper bound pair and, when in range, turned into the entry address `base + VPN*4`. The walker issues that single 32-bit read on a valid/ready request port and waits for the one-cycle response.

When the fetched entry has its valid bit set, the walker emits a one-cycle refill carrying the VPN tag, the 18-bit physical page number and the write-permission bit, so that the TLB can install the entry and the faulting access can be retried. When the entry is invalid, or the VPN lies outside the bounds, the walker emits a one-cycle page-fault pulse together with the full faulting virtual address. Only one walk is in flight at a time. The table base and both bounds are sampled at the moment a miss is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready_o` is 1 and `mem_req_valid_o`, `refill_valid_o` and `fault_valid_o` are 0.
- R2: A miss is accepted on a clock edge where `miss_valid_i` and `miss_ready_o` are both 1. `miss_ready_o` then stays 0 until the walk's result has been emitted, so only one walk is in flight.
- R3: The VPN is `miss_vaddr_i[31:12]`. It is in range when `pt_lo_i <= VPN <= pt_hi_i`, both bounds inclusive. An out-of-range VPN raises `fault_valid_o` in the second cycle after acceptance with `fault_vaddr_o` equal to the miss address, and no memory request is issued.
- R4: For an in-range VPN, `mem_req_valid_o` rises in the second cycle after acceptance with `mem_req_addr_o = pt_base_i + VPN*4`, taken modulo 2^32. The base and the bounds are those present at acceptance. The request is held stable until `mem_req_ready_i` is 1 and drops after that handshake.
- R5: If response bit 31 is 1, `refill_valid_o` pulses in the cycle after the response with `refill_vpn_o` equal to the VPN, `refill_ppn_o` equal to response bits [17:0] and `refill_wr_o` equal to response bit 30.
- R6: If response bit 31 is 0, `fault_valid_o` pulses in the cycle after the response with `fault_vaddr_o` equal to the full miss address.
- R7: `refill_valid_o` and `fault_valid_o` are never 1 together, and each stays high for exactly one cycle per walk.
- R8: In the cycle after a refill or fault pulse, `miss_ready_o` is 1 again, and a new miss can be accepted on that edge.
- R9: `mem_rsp_valid_i` has no effect unless a read is outstanding. A stray response while idle produces neither a refill nor a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request present |
| miss_ready_o | output | 1 | Walker idle and able to accept a miss |
| miss_vaddr_i | input | 32 | Virtual address that missed |
| pt_base_i | input | 32 | Physical start address of the current page table |
| pt_lo_i | input | 20 | Lowest VPN covered by the table |
| pt_hi_i | input | 20 | Highest VPN covered by the table |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | Entry address |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | 32 | Page-table entry |
| refill_valid_o | output | 1 | One-cycle refill pulse |
| refill_vpn_o | output | 20 | VPN tag for the refill |
| refill_ppn_o | output | 18 | Physical page number |
| refill_wr_o | output | 1 | Write permission of the page |
| fault_valid_o | output | 1 | One-cycle page-fault pulse |
| fault_vaddr_o | output | 32 | Faulting virtual address |

## Verification
Counting clock edges from acceptance, an out-of-range fault is due two edges later, the entry request appears two edges later, and a refill or fault is due one edge after the response handshake. The bench numbers every falling edge, so for each walk it knows in advance the exact falling-edge index where each pulse must appear. On every falling edge it compares both result strobes against that index, so a pulse that is early, late or doubled is caught. Between those points it samples the request port while it stalls the ready and response lines by different amounts.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } ptw_state_e;
endpackage

// File: rtl/ptw_bound_addr.sv
module ptw_bound_addr #(
  parameter int VPN_W     = 20,
  parameter int PADDR_W   = 32,
  parameter int PTE_BYTES = 4
) (
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [PADDR_W-1:0] base_i,
  input  logic [VPN_W-1:0]   lo_i,
  input  logic [VPN_W-1:0]   hi_i,
  output logic               in_range_o,
  output logic [PADDR_W-1:0] pte_addr_o
);
  localparam int SHIFT = $clog2(PTE_BYTES);

  logic [PADDR_W-1:0] offset;

  assign offset     = PADDR_W'(vpn_i) << SHIFT;
  assign pte_addr_o = base_i + offset;
  assign in_range_o = (vpn_i >= lo_i) && (vpn_i <= hi_i);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W     = 32,
  parameter int PPN_W     = 18,
  parameter int VALID_BIT = 31,
  parameter int WR_BIT    = 30
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic             valid_o,
  output logic             wr_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic unused_pte;

  assign valid_o    = pte_i[VALID_BIT];
  assign wr_o       = pte_i[WR_BIT];
  assign ppn_o      = pte_i[PPN_W-1:0];
  assign unused_pte = ^pte_i;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic miss_valid_i,
  input  logic in_range_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic rsp_ok_i,
  output logic miss_ready_o,
  output logic req_valid_o,
  output logic refill_o,
  output logic fault_o,
  output logic cap_miss_o,
  output logic cap_pte_o
);
  ptw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_valid_i) state_d = ST_CHECK;
      ST_CHECK: state_d = in_range_i ? ST_REQ : ST_FAULT;
      ST_REQ:   if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) state_d = rsp_ok_i ? ST_DONE : ST_FAULT;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign miss_ready_o = (state_q == ST_IDLE);
  assign req_valid_o  = (state_q == ST_REQ);
  assign refill_o     = (state_q == ST_DONE);
  assign fault_o      = (state_q == ST_FAULT);
  assign cap_miss_o   = (state_q == ST_IDLE) && miss_valid_i;
  assign cap_pte_o    = (state_q == ST_WAIT) && rsp_valid_i;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VADDR_W   = 32,
  parameter int OFFS_W    = 12,
  parameter int PADDR_W   = 32,
  parameter int PPN_W     = 18,
  parameter int PTE_W     = 32,
  parameter int PTE_BYTES = 4,
  parameter int VALID_BIT = 31,
  parameter int WR_BIT    = 30
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       miss_valid_i,
  output logic                       miss_ready_o,
  input  logic [VADDR_W-1:0]         miss_vaddr_i,
  input  logic [PADDR_W-1:0]         pt_base_i,
  input  logic [VADDR_W-OFFS_W-1:0]  pt_lo_i,
  input  logic [VADDR_W-OFFS_W-1:0]  pt_hi_i,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic [PADDR_W-1:0]         mem_req_addr_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [PTE_W-1:0]           mem_rsp_data_i,
  output logic                       refill_valid_o,
  output logic [VADDR_W-OFFS_W-1:0]  refill_vpn_o,
  output logic [PPN_W-1:0]           refill_ppn_o,
  output logic                       refill_wr_o,
  output logic                       fault_valid_o,
  output logic [VADDR_W-1:0]         fault_vaddr_o
);
  localparam int VPN_W = VADDR_W - OFFS_W;

  logic [VADDR_W-1:0] vaddr_q;
  logic [PADDR_W-1:0] base_q;
  logic [VPN_W-1:0]   lo_q, hi_q;
  logic [PPN_W-1:0]   ppn_q;
  logic               wr_q;

  logic               cap_miss, cap_pte;
  logic               in_range;
  logic               rsp_ok, rsp_wr;
  logic [PPN_W-1:0]   rsp_ppn;
  logic [VPN_W-1:0]   vpn;

  assign vpn = vaddr_q[VADDR_W-1:OFFS_W];

  ptw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .in_range_i   (in_range),
    .req_ready_i  (mem_req_ready_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_ok_i     (rsp_ok),
    .miss_ready_o (miss_ready_o),
    .req_valid_o  (mem_req_valid_o),
    .refill_o     (refill_valid_o),
    .fault_o      (fault_valid_o),
    .cap_miss_o   (cap_miss),
    .cap_pte_o    (cap_pte)
  );

  ptw_bound_addr #(
    .VPN_W     (VPN_W),
    .PADDR_W   (PADDR_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_bound (
    .vpn_i      (vpn),
    .base_i     (base_q),
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .in_range_o (in_range),
    .pte_addr_o (mem_req_addr_o)
  );

  ptw_pte_decode #(
    .PTE_W     (PTE_W),
    .PPN_W     (PPN_W),
    .VALID_BIT (VALID_BIT),
    .WR_BIT    (WR_BIT)
  ) u_decode (
    .pte_i   (mem_rsp_data_i),
    .valid_o (rsp_ok),
    .wr_o    (rsp_wr),
    .ppn_o   (rsp_ppn)
  );

  // table geometry is frozen for the whole walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      base_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (cap_miss) begin
      vaddr_q <= miss_vaddr_i;
      base_q  <= pt_base_i;
      lo_q    <= pt_lo_i;
      hi_q    <= pt_hi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppn_q <= '0;
      wr_q  <= 1'b0;
    end else if (cap_pte) begin
      ppn_q <= rsp_ppn;
      wr_q  <= rsp_wr;
    end
  end

  assign refill_vpn_o  = vpn;
  assign refill_ppn_o  = ppn_q;
  assign refill_wr_o   = wr_q;
  assign fault_vaddr_o = vaddr_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PADDR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               miss_valid_i,
  input logic               miss_ready_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [PADDR_W-1:0] mem_req_addr_o,
  input logic               refill_valid_o,
  input logic               fault_valid_o
);
  a_r2_one_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |=> !miss_ready_o);

  a_r2_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_o |-> !mem_req_valid_o);

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r4_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refill_valid_o && fault_valid_o));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_o || fault_valid_o) |=> !(refill_valid_o || fault_valid_o));

  a_r8_back_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_o || fault_valid_o) |=> miss_ready_o);
endmodule

bind pt_walker ptw_checker #(.PADDR_W(PADDR_W)) u_ptw_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .miss_valid_i    (miss_valid_i),
  .miss_ready_o    (miss_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .refill_valid_o  (refill_valid_o),
  .fault_valid_o   (fault_valid_o)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic [31:0] pt_base = '0;
  logic [19:0] pt_lo = '0, pt_hi = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [17:0] refill_ppn;
  logic        refill_wr;
  logic        fault_valid;
  logic [31:0] fault_vaddr;

  int checks = 0;
  int failures = 0;
  int ncyc = 0;
  int exp_ref = -1;
  int exp_flt = -1;
  bit run = 1'b0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i (clk), .rst_ni (rst_n),
    .miss_valid_i (miss_valid), .miss_ready_o (miss_ready), .miss_vaddr_i (miss_vaddr),
    .pt_base_i (pt_base), .pt_lo_i (pt_lo), .pt_hi_i (pt_hi),
    .mem_req_valid_o (req_valid), .mem_req_ready_i (req_ready), .mem_req_addr_o (req_addr),
    .mem_rsp_valid_i (rsp_valid), .mem_rsp_data_i (rsp_data),
    .refill_valid_o (refill_valid), .refill_vpn_o (refill_vpn), .refill_ppn_o (refill_ppn),
    .refill_wr_o (refill_wr), .fault_valid_o (fault_valid), .fault_vaddr_o (fault_vaddr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // strobe model: each result pulse is due at exactly one falling-edge index
  always @(negedge clk) begin
    if (run) begin
      ncyc++;
      chk(refill_valid == (ncyc == exp_ref), "R5/R7 refill strobe", 64'(refill_valid), 64'(ncyc == exp_ref));
      chk(fault_valid == (ncyc == exp_flt), "R3/R6/R7 fault strobe", 64'(fault_valid), 64'(ncyc == exp_flt));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [19:0] lo,
                      input logic [19:0] hi, input logic [31:0] pte, input int rd, input int ld);
    logic [19:0] vpn;
    logic [31:0] addr;
    bit          inr;
    int          n0;
    vpn  = va[31:12];
    addr = base + {10'b0, vpn, 2'b00};
    inr  = (vpn >= lo) && (vpn <= hi);
    step();
    n0 = ncyc;
    chk(miss_ready == 1'b1, "R8 ready before miss", 64'(miss_ready), 64'd1);
    miss_valid = 1'b1; miss_vaddr = va; pt_base = base; pt_lo = lo; pt_hi = hi;
    if (!inr)         exp_flt = n0 + 2;
    else if (pte[31]) exp_ref = n0 + 4 + rd + ld;
    else              exp_flt = n0 + 4 + rd + ld;
    step();
    // later changes to base and bounds must not matter
    miss_valid = 1'b0; pt_base = ~base; pt_lo = 20'hFFFFF; pt_hi = 20'h0;
    miss_vaddr = ~va;
    chk(miss_ready == 1'b0, "R2 busy after accept", 64'(miss_ready), 64'd0);
    chk(req_valid == 1'b0, "R4 no request during check", 64'(req_valid), 64'd0);
    step();
    if (!inr) begin
      chk(fault_vaddr == va, "R3 out-of-range fault address", 64'(fault_vaddr), 64'(va));
      chk(req_valid == 1'b0, "R3 no read when out of range", 64'(req_valid), 64'd0);
      step();
      chk(req_valid == 1'b0, "R3 no read when out of range", 64'(req_valid), 64'd0);
      chk(miss_ready == 1'b1, "R8 idle after fault", 64'(miss_ready), 64'd1);
      return;
    end
    chk(req_valid == 1'b1, "R4 request issued", 64'(req_valid), 64'd1);
    chk(req_addr == addr, "R4 entry address", 64'(req_addr), 64'(addr));
    for (int i = 0; i < rd; i++) begin
      step();
      chk(req_valid == 1'b1, "R4 request held", 64'(req_valid), 64'd1);
      chk(req_addr == addr, "R4 address held", 64'(req_addr), 64'(addr));
    end
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    chk(req_valid == 1'b0, "R4 request drops after handshake", 64'(req_valid), 64'd0);
    for (int i = 0; i < ld; i++) step();
    rsp_valid = 1'b1; rsp_data = pte;
    step();
    rsp_valid = 1'b0; rsp_data = 32'hDEAD_BEEF;
    chk(miss_ready == 1'b0, "R2 busy while result shown", 64'(miss_ready), 64'd0);
    if (pte[31]) begin
      chk(refill_vpn == vpn, "R5 refill tag", 64'(refill_vpn), 64'(vpn));
      chk(refill_ppn == pte[17:0], "R5 refill ppn", 64'(refill_ppn), 64'(pte[17:0]));
      chk(refill_wr == pte[30], "R5 refill write bit", 64'(refill_wr), 64'(pte[30]));
    end else begin
      chk(fault_vaddr == va, "R6 invalid-entry fault address", 64'(fault_vaddr), 64'(va));
    end
    step();
    chk(miss_ready == 1'b1, "R8 idle after result", 64'(miss_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(miss_ready == 1'b1, "R1 reset ready", 64'(miss_ready), 64'd1);
    chk(req_valid == 1'b0, "R1 reset request", 64'(req_valid), 64'd0);
    chk(refill_valid == 1'b0, "R1 reset refill", 64'(refill_valid), 64'd0);
    chk(fault_valid == 1'b0, "R1 reset fault", 64'(fault_valid), 64'd0);
    rst_n = 1'b1;
    run = 1'b1;
    step();
    // valid entry, writable, no stalls
    walk(32'h0001_2ABC, 32'h0040_0000, 20'h00010, 20'h00100, 32'hC002_1357, 0, 0);
    // valid, read-only, stalled request and late response
    walk(32'h0005_0123, 32'h1000_0000, 20'h00000, 20'hFFFFF, 32'h8003_FFFF, 2, 3);
    // invalid entry with other bits set
    walk(32'h0002_0FFF, 32'h0800_0000, 20'h00001, 20'h00400, 32'h7FFF_FFFF, 1, 1);
    // bound edges
    walk(32'h0001_0000, 32'h0040_0000, 20'h00010, 20'h00100, 32'h8000_0001, 0, 2);
    walk(32'h0010_0FFF, 32'h0040_0000, 20'h00010, 20'h00100, 32'hC001_0000, 1, 0);
    walk(32'h0010_1000, 32'h0040_0000, 20'h00010, 20'h00100, 32'h8000_0000, 0, 0);
    walk(32'h0000_F800, 32'h0040_0000, 20'h00010, 20'h00100, 32'h8000_0000, 0, 0);
    // address wraps modulo 2^32
    walk(32'h0000_5000, 32'hFFFF_FFF0, 20'h00000, 20'h00010, 32'h8000_0ABC, 0, 0);
    // R9 stray response while idle
    rsp_valid = 1'b1; rsp_data = 32'h8000_1234;
    step();
    rsp_valid = 1'b0;
    step(); step();
    chk(miss_ready == 1'b1, "R9 stray response ignored", 64'(miss_ready), 64'd1);
    chk(req_valid == 1'b0, "R9 no request from stray response", 64'(req_valid), 64'd0);
    walk(32'hFFFF_F000, 32'h0000_1000, 20'hFFFF0, 20'hFFFFF, 32'h8002_4680, 3, 0);
    step(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule